// File: doc/BRIEF.md
# Nearest-Delay Scaler Search Engine

This block picks the 8-bit scaler that sets one SPI timing delay. The timing delays are the gap from chip select to the first clock edge, the gap from the last clock edge to chip-select release, and the idle gap between two transfers. A request gives the desired delay in nanoseconds, the period of the prescaled functional clock in nanoseconds, and an offset bit. The offset bit is 0 for the two chip-select gaps and 1 for the between-transfer gap. Scaler s then gives a delay of period × (s + 1 + offset).

A one-cycle `start` pulse while the engine is idle latches the three inputs and begins the search. Each clock cycle the engine tries one candidate, starting at 0 and counting upward. A candidate whose delay falls short of the target is rejected. Among the candidates that remain, the engine keeps the one with the smallest excess over the target. The search ends at the first exact match, or after candidate 255. `done` then pulses for one cycle, and `scaler` and `saturated` hold the answer until the next search finishes. If no candidate reaches the target, the answer is 255 with `saturated` set.

Top module: `delay_scaler_search`

## Requirements
- R1: After reset, `busy`, `done` and `saturated` are 0 and `scaler` is 0.
- R2: A `start` pulse while `busy` is 0 latches `desired_ns`, `period_ns` and `offset_sel`, and `busy` is 1 from the next cycle. A `start` while `busy` is 1 is ignored, as are input changes during a search. The result is that of the latched request, and exactly one `done` follows.
- R3: Candidate s (0..255) has delay `period_ns` × (s + 1 + `offset_sel`), computed without overflow for every 32-bit period and every scaler.
- R4: A candidate whose delay is below `desired_ns` is never returned unless `saturated` is 1.
- R5: Among the candidates whose delay is at least `desired_ns`, the result is the one with the smallest excess. On equal excess the lower scaler wins.
- R6: When candidate k gives zero excess, the search stops there: `busy` is high for exactly k+1 cycles and the result is k.
- R7: Without an exact match, all 256 candidates are tried and `busy` is high for exactly 256 cycles.
- R8: When no candidate reaches `desired_ns`, the result is 255 with `saturated` = 1. Otherwise `saturated` = 0.
- R9: `done` is high for exactly one cycle, the first cycle with `busy` low after a search. `scaler` and `saturated` are valid then and stay unchanged until the next search ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a search when idle |
| desired_ns | input | 32 | Target delay in ns |
| period_ns | input | 32 | Prescaled clock period in ns |
| offset_sel | input | 1 | Candidate offset: 0 for chip-select gaps, 1 for between-transfer gap |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result-valid pulse |
| scaler | output | 8 | Chosen scaler |
| saturated | output | 1 | No candidate reached the target |

## Verification
The hardest conditions to reach from the ports are the edges of the candidate range. One is an exact match on the very last candidate, where the early exit and the range end coincide. The other is the 41-bit product at the largest period. The stimulus reaches these with targets equal to 256 × period or 257 × period, and with a period of all ones. The bench also tries a zero period, which makes every candidate's delay equal, to exercise the lower-scaler rule on ties. A second `start` is issued mid-search, together with new input values, to show that the running search is not disturbed.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic {
    DSS_IDLE = 1'b0,
    DSS_RUN  = 1'b1
  } dss_state_e;
endpackage

// File: rtl/dss_cand_eval.sv
module dss_cand_eval #(
  parameter int PERIOD_W = 32,
  parameter int DELAY_W  = 32,
  parameter int SCALER_W = 8,
  parameter int PROD_W   = PERIOD_W + SCALER_W + 1
) (
  input  logic [PERIOD_W-1:0] period,
  input  logic [DELAY_W-1:0]  desired,
  input  logic                offset,
  input  logic [SCALER_W-1:0] cand,
  output logic                meets,
  output logic                exact,
  output logic [PROD_W-1:0]   excess
);
  function automatic logic [PROD_W-1:0] mult_delay(input logic [PERIOD_W-1:0] p,
                                                   input logic [SCALER_W-1:0] s,
                                                   input logic o);
    logic [PROD_W-1:0] factor;
    factor = PROD_W'(s) + PROD_W'(1) + PROD_W'(o);
    return PROD_W'(p) * factor;
  endfunction

  logic [PROD_W-1:0] cand_delay;
  logic [PROD_W-1:0] target;

  always_comb begin
    cand_delay = mult_delay(period, cand, offset);
    target     = PROD_W'(desired);
    meets      = cand_delay >= target;
    excess     = meets ? cand_delay - target : '0;
    exact      = meets && (excess == '0);
  end
endmodule

// File: rtl/dss_ctrl.sv
module dss_ctrl
  import dss_pkg::*;
#(
  parameter int SCALER_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                hit,
  output logic                busy,
  output logic                launch,
  output logic                finish,
  output logic [SCALER_W-1:0] cand
);
  localparam logic [SCALER_W-1:0] LAST = '1;

  dss_state_e state;

  assign busy   = (state == DSS_RUN);
  assign launch = (state == DSS_IDLE) && start;
  assign finish = busy && (hit || cand == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= DSS_IDLE;
      cand  <= '0;
    end else if (launch) begin
      state <= DSS_RUN;
      cand  <= '0;
    end else if (finish) begin
      state <= DSS_IDLE;
    end else if (busy) begin
      cand <= cand + 1'b1;
    end
  end

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !finish |=> busy); // R7
  AST_CAND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !finish |=> cand == $past(cand) + 1'b1); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !finish |=> busy && cand != '0); // R2
endmodule

// File: rtl/dss_best_track.sv
module dss_best_track #(
  parameter int SCALER_W = 8,
  parameter int PROD_W   = 41
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  logic                busy,
  input  logic                finish,
  input  logic                meets,
  input  logic [PROD_W-1:0]   excess,
  input  logic [SCALER_W-1:0] cand,
  output logic                done,
  output logic [SCALER_W-1:0] scaler,
  output logic                saturated
);
  localparam logic [SCALER_W-1:0] MAX_S = '1;

  logic                found;
  logic [PROD_W-1:0]   best_exc;
  logic [SCALER_W-1:0] best_idx;
  logic                take;

  assign take = busy && meets && (!found || excess < best_exc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found     <= 1'b0;
      best_exc  <= '1;
      best_idx  <= '0;
      done      <= 1'b0;
      scaler    <= '0;
      saturated <= 1'b0;
    end else begin
      done <= finish;
      if (launch) begin
        found    <= 1'b0;
        best_exc <= '1;
        best_idx <= '0;
      end else if (take) begin
        found    <= 1'b1;
        best_exc <= excess;
        best_idx <= cand;
      end
      if (finish) begin
        scaler    <= take ? cand : (found ? best_idx : MAX_S);
        saturated <= !(take || found);
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_SAT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    done && saturated |-> scaler == MAX_S); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(scaler) && $stable(saturated)); // R9
endmodule

// File: rtl/delay_scaler_search.sv
module delay_scaler_search #(
  parameter int PERIOD_W = 32,
  parameter int DELAY_W  = 32,
  parameter int SCALER_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [DELAY_W-1:0]  desired_ns,
  input  logic [PERIOD_W-1:0] period_ns,
  input  logic                offset_sel,
  output logic                busy,
  output logic                done,
  output logic [SCALER_W-1:0] scaler,
  output logic                saturated
);
  localparam int PROD_W = ((PERIOD_W + SCALER_W + 1) > DELAY_W + 1) ?
                          (PERIOD_W + SCALER_W + 1) : (DELAY_W + 1);

  logic [DELAY_W-1:0]  desired_q;
  logic [PERIOD_W-1:0] period_q;
  logic                offset_q;
  logic                launch, finish, meets, exact;
  logic [PROD_W-1:0]   excess;
  logic [SCALER_W-1:0] cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desired_q <= '0;
      period_q  <= '0;
      offset_q  <= 1'b0;
    end else if (launch) begin
      desired_q <= desired_ns;
      period_q  <= period_ns;
      offset_q  <= offset_sel;
    end
  end

  dss_ctrl #(.SCALER_W(SCALER_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .hit(exact),
    .busy(busy), .launch(launch), .finish(finish), .cand(cand)
  );

  dss_cand_eval #(.PERIOD_W(PERIOD_W), .DELAY_W(DELAY_W),
                  .SCALER_W(SCALER_W), .PROD_W(PROD_W)) u_eval (
    .period(period_q), .desired(desired_q), .offset(offset_q), .cand(cand),
    .meets(meets), .exact(exact), .excess(excess)
  );

  dss_best_track #(.SCALER_W(SCALER_W), .PROD_W(PROD_W)) u_track (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .finish(finish),
    .meets(meets), .excess(excess), .cand(cand),
    .done(done), .scaler(scaler), .saturated(saturated)
  );

  function automatic logic [PROD_W-1:0] chk_delay(input logic [SCALER_W-1:0] s);
    return PROD_W'(period_q) * (PROD_W'(s) + PROD_W'(offset_q) + PROD_W'(1));
  endfunction

  AST_NO_SHORT_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    done && !saturated |-> chk_delay(scaler) >= PROD_W'(desired_q)); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_EXACT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && exact |=> !busy && done); // R6
endmodule

// File: tb/tb_delay_scaler_search.sv
module tb_delay_scaler_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] desired_ns = '0;
  logic [31:0] period_ns = '0;
  logic        offset_sel = 1'b0;
  logic        busy, done, saturated;
  logic [7:0]  scaler;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [7:0] s;
    logic       sat;
    int         n;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  delay_scaler_search dut (
    .clk(clk), .rst_n(rst_n), .start(start), .desired_ns(desired_ns),
    .period_ns(period_ns), .offset_sel(offset_sel), .busy(busy), .done(done),
    .scaler(scaler), .saturated(saturated)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] d, input logic [31:0] p,
                                 input logic o, input string tag);
    exp_t e;
    logic [63:0] best;
    bit found;
    found = 0; best = 0;
    e.s = 8'd255; e.sat = 1'b1; e.n = 256; e.tag = tag;
    for (int s = 0; s < 256; s++) begin
      logic [63:0] dl;
      dl = 64'(p) * 64'(s + 1 + int'(o));
      if (dl >= 64'(d)) begin
        if (!found || dl - 64'(d) < best) begin
          found = 1; best = dl - 64'(d); e.s = 8'(s); e.sat = 1'b0;
        end
        if (dl == 64'(d)) begin
          e.n = s + 1;
          break;
        end
      end
    end
    return e;
  endfunction

  // monitor
  int busy_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cnt++;
      if (done) begin
        if (sb.size() == 0) begin
          check("R2 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " scaler"}, 64'(scaler), 64'(e.s));
          check({"R8 ", e.tag, " saturated"}, 64'(saturated), 64'(e.sat));
          check({e.tag, " busy cycles"}, 64'(busy_cnt), 64'(e.n));
        end
        busy_cnt = 0;
      end
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!done);
    @(negedge clk);
    check("R9 done one cycle", 64'(done), 0);
  endtask

  task automatic run(input logic [31:0] d, input logic [31:0] p,
                     input logic o, input string tag);
    sb.push_back(model(d, p, o, tag));
    @(negedge clk);
    desired_ns = d; period_ns = p; offset_sel = o; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({"R2 busy after start ", tag}, 64'(busy), 1);
    wait_done();
  endtask

  initial begin
    #200000;
    check("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", 64'(busy), 0);
    check("R1 done", 64'(done), 0);
    check("R1 saturated", 64'(saturated), 0);
    check("R1 scaler", 64'(scaler), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(100, 10, 0, "R6 exact off0");
    run(100, 10, 1, "R3 exact off1");
    run(105, 10, 0, "R5 least excess");
    run(50, 7, 1, "R5 off1 rounding");
    run(0, 10, 0, "R7 zero target");
    run(2560, 10, 0, "R6 exact last off0");
    run(2570, 10, 1, "R6 exact last off1");
    run(2561, 10, 0, "R8 just above max");
    run(3000, 10, 1, "R8 saturate off1");
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R3 max period exact");
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R3 max period off1");
    run(32'hFFFF_FFFF, 32'h0100_0000, 0, "R3 wide product");
    run(0, 0, 0, "R5 zero period tie");
    run(5, 0, 1, "R4 zero period short");

    // R9 result held after done
    repeat (5) @(negedge clk);
    check("R9 scaler held", 64'(scaler), 255);
    check("R9 saturated held", 64'(saturated), 1);

    // R2 start while busy ignored, inputs changed mid-search
    sb.push_back(model(105, 10, 0, "R2 ignore restart"));
    @(negedge clk);
    desired_ns = 105; period_ns = 10; offset_sel = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    desired_ns = 20; period_ns = 10; offset_sel = 1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy kept", 64'(busy), 1);
    wait_done();
    repeat (10) @(negedge clk);
    check("R2 no second done", 64'(sb.size()), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule